// File: doc/BRIEF.md
# Request Buffer Admission Counter

This block sits beside the request buffer of a memory controller and keeps a running count of how many requests the buffer holds. Each accepted request raises a store strobe carrying its bank number and a read/write flag. Each request that leaves the buffer raises a remove strobe with the same two fields. From these counts the block produces one registered flag that tells the front end whether another request may be admitted.

A static parameter picks the counting scheme. In per-bank mode there is one occupancy counter for each bank. The admission flag follows only the bank that received the latest store. In read/write mode there are two counters, one for reads and one for writes. Admission then requires both counters to be below the buffer size. Both schemes share one saturating counter fabric; only the routing of strobes to counters and the final comparison differ. The block does not hold the requests, does not schedule them and applies no memory timing.

Top module: `rq_admit_counter`

## Requirements
- R1: While reset is held and in the first cycle after it, every counter is zero, the recorded latest bank is bank 0 and `space_ok` is 1.
- R2: In per-bank mode, a store adds one to the counter of `st_bank` and records `st_bank` as the latest stored bank.
- R3: A remove subtracts one from the counter it names, which is the counter of `rm_bank` in per-bank mode. A remove leaves the recorded latest bank unchanged, and a remove alone never clears `space_ok`.
- R4: In per-bank mode, `space_ok` is 1 exactly when the counter of the latest stored bank is strictly below `BUF_DEPTH`. The counters of all other banks have no effect on the flag.
- R5: In read/write mode, a store with `st_is_rd`=1 adds one to the read counter and a store with `st_is_rd`=0 adds one to the write counter. A remove subtracts one from the read counter when `rm_is_rd`=1 and from the write counter when `rm_is_rd`=0.
- R6: In read/write mode, `space_ok` is 1 exactly when the read count and the write count are each strictly below `BUF_DEPTH`.
- R7: A store and a remove in the same cycle that hit the same counter leave that counter unchanged. When they hit different counters, both updates apply.
- R8: Each counter is `$clog2(BUF_DEPTH+1)` bits wide. It holds at its all-ones value on further stores and holds at zero on further removes, and it never wraps.
- R9: `space_ok` is a register. It shows the state that results from the strobes of a cycle at the next rising clock edge, and it does not change in a cycle that follows a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_vld | input | 1 | A request enters the buffer this cycle |
| st_bank | input | $clog2(NUM_BANKS) | Bank of the entering request |
| st_is_rd | input | 1 | Entering request is a read (1) or a write (0) |
| rm_vld | input | 1 | A request leaves the buffer this cycle |
| rm_bank | input | $clog2(NUM_BANKS) | Bank of the leaving request |
| rm_is_rd | input | 1 | Leaving request is a read (1) or a write (0) |
| space_ok | output | 1 | Registered admission flag |

## Verification
Store and remove can occur in the same cycle, and that is where a counter is most likely to go wrong. The bench drives both strobes in one cycle twice. The first time they name the same bank and direction, so the counter must stay where it was. The second time they name different counters, so one counter must rise while the other falls. Both instances, one per mode, get the same stimulus, and a reference model computes each expected flag. Runs of stores pushed past the all-ones value, and removes that continue below zero, then show whether saturation leaves the counts that later decide the flag.

// File: rtl/rbac_pkg.sv
`timescale 1ns/1ps
package rbac_pkg;

    // Counting scheme selected at elaboration time
    typedef enum logic {
        OCC_PER_BANK   = 1'b0,
        OCC_READ_WRITE = 1'b1
    } occ_mode_e;

    // Net request to one counter after store/remove merging
    typedef struct packed {
        logic up;
        logic down;
    } occ_step_t;

    // Bits needed to index n items (at least one)
    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Bits needed to hold the value n itself
    function automatic int val_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // A simultaneous up and down on one counter cancel out
    function automatic occ_step_t merge_step(input logic up, input logic down);
        occ_step_t s;
        s.up   = up & ~down;
        s.down = down & ~up;
        return s;
    endfunction

endpackage

// File: rtl/rbac_sat_cnt.sv
`timescale 1ns/1ps
module rbac_sat_cnt #(
    parameter int W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  rbac_pkg::occ_step_t step,
    output logic [W-1:0]        cnt_q,
    output logic [W-1:0]        cnt_d
);
    localparam logic [W-1:0] TOP = '1;

    // Next value: saturate at both ends instead of wrapping
    always_comb begin
        cnt_d = cnt_q;
        if (step.up && (cnt_q != TOP)) begin
            cnt_d = cnt_q + W'(1);
        end else if (step.down && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rbac_route.sv
`timescale 1ns/1ps
module rbac_route #(
    parameter rbac_pkg::occ_mode_e MODE = rbac_pkg::OCC_PER_BANK,
    parameter int NCNT   = 8,
    parameter int IDX_W  = 3,
    parameter int BANK_W = 3
) (
    input  logic              vld,
    input  logic [BANK_W-1:0] bank,
    input  logic              is_rd,
    output logic [NCNT-1:0]   hit
);
    logic [IDX_W-1:0] idx;

    // Map a request onto a counter index: bank number or direction
    always_comb begin
        if (MODE == rbac_pkg::OCC_READ_WRITE) begin
            idx = is_rd ? IDX_W'(0) : IDX_W'(1);
        end else begin
            idx = IDX_W'(bank);
        end
    end

    for (genvar i = 0; i < NCNT; i++) begin : g_dec
        assign hit[i] = vld && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/rbac_space.sv
`timescale 1ns/1ps
module rbac_space #(
    parameter rbac_pkg::occ_mode_e MODE = rbac_pkg::OCC_PER_BANK,
    parameter int NCNT      = 8,
    parameter int CNT_W     = 4,
    parameter int BANK_W    = 3,
    parameter int BUF_DEPTH = 8
) (
    input  logic [CNT_W-1:0]  cnt_d [NCNT],
    input  logic [BANK_W-1:0] last_d,
    output logic              space
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BUF_DEPTH);

    logic [CNT_W-1:0] sel;
    logic             all_below;

    // Counter of the most recently stored bank
    always_comb begin
        sel = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (BANK_W'(i) == last_d) begin
                sel = cnt_d[i];
            end
        end
    end

    // Every counter below the limit
    always_comb begin
        all_below = 1'b1;
        for (int i = 0; i < NCNT; i++) begin
            if (cnt_d[i] >= LIMIT) begin
                all_below = 1'b0;
            end
        end
    end

    assign space = (MODE == rbac_pkg::OCC_READ_WRITE) ? all_below : (sel < LIMIT);
endmodule

// File: rtl/rq_admit_counter.sv
`timescale 1ns/1ps
module rq_admit_counter #(
    parameter int NUM_BANKS = 8,
    parameter int BUF_DEPTH = 8,
    parameter rbac_pkg::occ_mode_e MODE = rbac_pkg::OCC_PER_BANK
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  st_vld,
    input  logic [rbac_pkg::idx_bits(NUM_BANKS)-1:0] st_bank,
    input  logic                                  st_is_rd,
    input  logic                                  rm_vld,
    input  logic [rbac_pkg::idx_bits(NUM_BANKS)-1:0] rm_bank,
    input  logic                                  rm_is_rd,
    output logic                                  space_ok
);
    import rbac_pkg::*;

    localparam int BANK_W = idx_bits(NUM_BANKS);
    localparam int NCNT   = (MODE == OCC_READ_WRITE) ? 2 : NUM_BANKS;
    localparam int IDX_W  = idx_bits(NCNT);
    localparam int CNT_W  = val_bits(BUF_DEPTH);

    logic [NCNT-1:0]   st_hit;
    logic [NCNT-1:0]   rm_hit;
    logic [CNT_W-1:0]  cnt_q [NCNT];
    logic [CNT_W-1:0]  cnt_d [NCNT];
    logic [BANK_W-1:0] last_q;
    logic [BANK_W-1:0] last_d;
    logic              space_nxt;
    logic [NCNT*CNT_W-1:0] occ_flat;

    rbac_route #(.MODE(MODE), .NCNT(NCNT), .IDX_W(IDX_W), .BANK_W(BANK_W)) u_st_route (
        .vld   (st_vld),
        .bank  (st_bank),
        .is_rd (st_is_rd),
        .hit   (st_hit)
    );

    rbac_route #(.MODE(MODE), .NCNT(NCNT), .IDX_W(IDX_W), .BANK_W(BANK_W)) u_rm_route (
        .vld   (rm_vld),
        .bank  (rm_bank),
        .is_rd (rm_is_rd),
        .hit   (rm_hit)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        rbac_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .step  (merge_step(st_hit[i], rm_hit[i])),
            .cnt_q (cnt_q[i]),
            .cnt_d (cnt_d[i])
        );
        assign occ_flat[i*CNT_W +: CNT_W] = cnt_q[i];
    end

    // Latest stored bank; removes never touch it
    assign last_d = st_vld ? st_bank : last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
        end else begin
            last_q <= last_d;
        end
    end

    rbac_space #(
        .MODE(MODE), .NCNT(NCNT), .CNT_W(CNT_W), .BANK_W(BANK_W), .BUF_DEPTH(BUF_DEPTH)
    ) u_space (
        .cnt_d  (cnt_d),
        .last_d (last_d),
        .space  (space_nxt)
    );

    // Registered flag, evaluated on the post-update state
    always_ff @(posedge clk) begin
        if (rst) begin
            space_ok <= 1'b1;
        end else begin
            space_ok <= space_nxt;
        end
    end
endmodule

// File: rtl/rq_admit_chk.sv
`timescale 1ns/1ps
module rq_admit_chk #(
    parameter int NCNT  = 8,
    parameter int CNT_W = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  st_vld,
    input logic                  rm_vld,
    input logic                  space_ok,
    input logic [NCNT*CNT_W-1:0] occ_flat
);
    localparam logic [CNT_W-1:0] TOP = '1;

    int   total;
    logic all_mid;

    always_comb begin
        total   = 0;
        all_mid = 1'b1;
        for (int i = 0; i < NCNT; i++) begin
            total = total + int'(occ_flat[i*CNT_W +: CNT_W]);
            if (occ_flat[i*CNT_W +: CNT_W] == '0 || occ_flat[i*CNT_W +: CNT_W] == TOP) begin
                all_mid = 1'b0;
            end
        end
    end

    // R1
    rst_space_chk: assert property (@(posedge clk) rst |=> space_ok);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!st_vld && !rm_vld) |=> $stable(space_ok));

    // R3
    rm_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (rm_vld && !st_vld) |=> !$fell(space_ok));

    // R7
    pair_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (st_vld && rm_vld && all_mid) |=> (total == $past(total)));

    for (genvar i = 0; i < NCNT; i++) begin : g_c
        // R8
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            (occ_flat[i*CNT_W +: CNT_W] == TOP) |=> (occ_flat[i*CNT_W +: CNT_W] >= TOP - CNT_W'(1)));
        // R8
        no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
            (occ_flat[i*CNT_W +: CNT_W] == '0) |=> (occ_flat[i*CNT_W +: CNT_W] <= CNT_W'(1)));
    end
endmodule

bind rq_admit_counter rq_admit_chk #(.NCNT(NCNT), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .st_vld   (st_vld),
    .rm_vld   (rm_vld),
    .space_ok (space_ok),
    .occ_flat (occ_flat)
);

// File: tb/rq_admit_counter_test.sv
`timescale 1ns/1ps
module rq_admit_counter_test;
    localparam int NB    = 4;
    localparam int DEPTH = 4;
    localparam int MAXV  = 7;   // all-ones of a 3-bit counter

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       st_vld = 1'b0, rm_vld = 1'b0;
    logic [1:0] st_bank = '0, rm_bank = '0;
    logic       st_is_rd = 1'b0, rm_is_rd = 1'b0;
    logic       sp_bank, sp_rw;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // Reference model state
    int bcnt [NB];
    int last_b = 0;
    int rdc = 0;
    int wrc = 0;

    // Scoreboard queues
    logic [1:0] exp_q[$];
    int         stamp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    rq_admit_counter #(.NUM_BANKS(NB), .BUF_DEPTH(DEPTH), .MODE(rbac_pkg::OCC_PER_BANK)) uut (
        .clk(clk), .rst(rst), .st_vld(st_vld), .st_bank(st_bank), .st_is_rd(st_is_rd),
        .rm_vld(rm_vld), .rm_bank(rm_bank), .rm_is_rd(rm_is_rd), .space_ok(sp_bank)
    );

    rq_admit_counter #(.NUM_BANKS(NB), .BUF_DEPTH(DEPTH), .MODE(rbac_pkg::OCC_READ_WRITE)) uut_rw (
        .clk(clk), .rst(rst), .st_vld(st_vld), .st_bank(st_bank), .st_is_rd(st_is_rd),
        .rm_vld(rm_vld), .rm_bank(rm_bank), .rm_is_rd(rm_is_rd), .space_ok(sp_rw)
    );

    function automatic int sat(input int c, input bit up, input bit dn);
        if (up && !dn) return (c == MAXV) ? MAXV : c + 1;
        if (dn && !up) return (c == 0) ? 0 : c - 1;
        return c;
    endfunction

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: one cycle of stimulus, model update, expectation pushed
    task automatic step(input bit s, input int sb, input bit sr,
                        input bit r, input int rb, input bit rr, input string tag);
        logic eb, er;
        @(negedge clk);
        st_vld = s; st_bank = 2'(sb); st_is_rd = sr;
        rm_vld = r; rm_bank = 2'(rb); rm_is_rd = rr;
        for (int b = 0; b < NB; b++) bcnt[b] = sat(bcnt[b], s && sb == b, r && rb == b);
        if (s) last_b = sb;
        rdc = sat(rdc, s && sr, r && rr);
        wrc = sat(wrc, s && !sr, r && !rr);
        eb = (bcnt[last_b] < DEPTH);
        er = (rdc < DEPTH) && (wrc < DEPTH);
        exp_q.push_back({eb, er});
        stamp_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare once a clock edge has passed since the push
    always @(negedge clk) begin
        if (exp_q.size() > 0 && stamp_q[0] < cyc) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            void'(stamp_q.pop_front());
            t = tag_q.pop_front();
            check1(t, "per-bank", sp_bank, e[1]);
            check1(t, "read/write", sp_rw, e[0]);
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        for (int b = 0; b < NB; b++) bcnt[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: flag high during reset
        check1("R1", "per-bank reset", sp_bank, 1'b1);
        check1("R1", "read/write reset", sp_rw, 1'b1);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, "R1");
        // R2 R4 R5 R6: fill bank 2 with reads up to the limit
        for (int k = 0; k < 4; k++) step(1, 2, 1, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R9");
        // R4: latest bank moves to bank 1, bank 2 still full
        step(1, 1, 0, 0, 0, 0, "R4");
        // R3: remove from bank 2 does not move latest bank
        step(0, 0, 0, 1, 2, 1, "R3");
        step(1, 2, 1, 0, 0, 0, "R6");
        // R7: same counter, same cycle
        step(1, 2, 1, 1, 2, 1, "R7");
        // R7: different counters, same cycle
        step(1, 3, 0, 1, 2, 1, "R7");
        // R8: overflow of bank 0 / write counter
        for (int k = 0; k < 9; k++) step(1, 0, 0, 0, 0, 0, "R8");
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, 0, "R8");
        // R8: underflow of bank 1 / write counter
        for (int k = 0; k < 6; k++) step(0, 0, 0, 1, 1, 0, "R8");
        for (int k = 0; k < 4; k++) step(1, 1, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, "R9");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule